// File: doc/BRIEF.md
# Serial Debug Read-Byte Sequencer with Target Acknowledge

This block sits behind the bit-level front end of a single-wire debug link. It collects an 8-bit command code and a 24-bit memory address from the host, one sampled bit at a time. A recognised read-byte command turns into a request toward the processor side, which steals one execution slot to perform the access. The block keeps the request open until the processor returns a done strobe with the byte, then latches that byte.

Completion is reported back to the host by a pulse that the target, not the host, drives on the shared wire. The pulse drives the line low for a fixed number of debug clocks, drives it high for one clock, and then releases it. Only after that may the host clock the byte out, most significant bit first.

Entering stop mode while a request is open drops the command silently, with no pulse. A 3-bit status field records this outcome, and also a busy condition and a clean completion.

Top module: `dbg_rd_seq`

## Requirements
- R1: The command is taken as 8 code bits followed by 24 address bits, each MSB first, one bit per cycle with `rx_bit_vld` high. Code 8'hE0 means read byte. The clock edge after the last address bit is sampled starts `mem_req`, and from that edge `mem_addr` holds the address.
- R2: When the first 8 bits do not equal 8'hE0, they are dropped with no request. The receiver then expects a fresh code.
- R3: `mem_req` stays high until a cycle in which `mem_done` is high. `mem_rdata` is captured in that cycle, and `mem_req` is low from the next edge.
- R4: From the edge that samples `mem_done`, `line_oe`=1 with `line_out`=0 for 16 cycles. Then `line_oe`=1 with `line_out`=1 for 1 cycle, then `line_oe`=0. `line_oe` is 0 at all other times.
- R5: A `tx_req` given before the acknowledge has ended produces no `tx_bit_vld`. After the acknowledge, each `tx_req` yields `tx_bit_vld`=1 on the next cycle, carrying the byte MSB first, and 8 requests return the block to idle.
- R6: When `stop_mode` is high while `mem_req` is high, the request is dropped and no acknowledge follows. `cmd_status` becomes 3'b001 and keeps that value until a later command completes.
- R7: A completed access sets `cmd_status` to 3'b000.
- R8: While a command is pending, `cmd_status` reads 3'b100. Host bits received from then until the block is idle again are ignored: `mem_addr` does not change and no second request follows.
- R9: After reset, `mem_req`=0, `line_oe`=0, `tx_bit_vld`=0 and `cmd_status`=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_vld | input | 1 | Sampled host bit valid |
| rx_bit | input | 1 | Sampled host bit |
| tx_req | input | 1 | Host asks for the next read-data bit |
| tx_bit | output | 1 | Read-data bit |
| tx_bit_vld | output | 1 | `tx_bit` valid |
| line_oe | output | 1 | Target drives the debug wire |
| line_out | output | 1 | Level driven on the wire |
| stop_mode | input | 1 | Processor entering stop mode |
| mem_req | output | 1 | Slot request to processor |
| mem_addr | output | 24 | Address of requested byte |
| mem_done | input | 1 | One-cycle completion strobe |
| mem_rdata | input | 8 | Byte returned with `mem_done` |
| cmd_status | output | 3 | 000 done, 001 dropped by stop, 100 busy |

## Verification
The bench builds the block with its default parameters: 8-bit codes, 24-bit addresses, an 8-bit data byte and a 16-cycle low phase. These widths make it cheap to sweep all 256 code values, which covers every rejected code. They also allow a walking-one sweep over each address bit, with processor latencies from one to five cycles. At this width every acknowledge phase can be checked cycle by cycle, and bits injected while a command is pending show that stray host traffic has no effect.

// File: rtl/dbg_seq_pkg.sv
`timescale 1ns/1ps
package dbg_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PEND, SQ_ACK, SQ_DATA} sq_state_e;
  localparam logic [2:0] STS_OK   = 3'b000;
  localparam logic [2:0] STS_DROP = 3'b001;
  localparam logic [2:0] STS_BUSY = 3'b100;
endpackage

// File: rtl/dbg_cmd_rx.sv
`timescale 1ns/1ps
module dbg_cmd_rx #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 24,
  parameter logic [CODE_W-1:0] RD_CODE = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              cmd_vld,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int TOT  = CODE_W + ADDR_W;
  localparam int CNTW = $clog2(TOT + 1);
  localparam logic [CNTW-1:0] CODE_LAST = CNTW'(CODE_W - 1);
  localparam logic [CNTW-1:0] ALL_LAST  = CNTW'(TOT - 1);

  logic [CNTW-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-2:0] sr_q, sr_d;
  logic [ADDR_W-1:0] sr_nx;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign sr_nx = {sr_q, bit_in};

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    vld_d  = 1'b0;
    addr_d = addr_q;
    if (!en) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      sr_d = sr_nx[ADDR_W-2:0];
      if (cnt_q == CODE_LAST && sr_nx[CODE_W-1:0] != RD_CODE) begin
        cnt_d = '0;
      end else if (cnt_q == ALL_LAST) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        addr_d = sr_nx;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign cmd_vld  = vld_q;
  assign cmd_addr = addr_q;

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R1
endmodule

// File: rtl/dbg_ack_gen.sv
`timescale 1ns/1ps
module dbg_ack_gen #(
  parameter int LOW_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic oe,
  output logic lvl,
  output logic done
);
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_CYC);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign oe   = act_q;
  assign lvl  = act_q && (cnt_q == LAST);
  assign done = act_q && (cnt_q == LAST);

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && lvl && !start) |=> !oe); // R4
  AST_ACK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (oe && !lvl)); // R4
endmodule

// File: rtl/dbg_data_tx.sv
`timescale 1ns/1ps
module dbg_data_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         req,
  input  logic [W-1:0] data,
  output logic         bit_o,
  output logic         bit_vld,
  output logic         last
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] TOP = IW'(W - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic          bit_q, bit_d;
  logic          vld_q, vld_d;

  assign last = en && req && (idx_q == TOP);

  always_comb begin
    idx_d = idx_q;
    bit_d = bit_q;
    vld_d = 1'b0;
    if (!en) begin
      idx_d = '0;
    end else if (req) begin
      bit_d = data[TOP - idx_q];
      vld_d = 1'b1;
      idx_d = last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o   = bit_q;
  assign bit_vld = vld_q;

  AST_TX_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !req) |=> !bit_vld); // R5
endmodule

// File: rtl/dbg_rd_seq.sv
`timescale 1ns/1ps
module dbg_rd_seq
  import dbg_seq_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int ACK_LOW = 16,
  parameter logic [CODE_W-1:0] RD_CODE = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              tx_req,
  output logic              tx_bit,
  output logic              tx_bit_vld,
  output logic              line_oe,
  output logic              line_out,
  input  logic              stop_mode,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        cmd_status
);
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  sq_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [2:0]        sts_q, sts_d;
  logic              ack_start, ack_done, tx_last;
  logic              cmd_vld;
  logic [ADDR_W-1:0] cmd_addr;

  dbg_cmd_rx #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .RD_CODE(RD_CODE)) u_rx (
    .clk(clk), .rst_n(rst_sn), .en(st_q == SQ_IDLE),
    .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .cmd_vld(cmd_vld), .cmd_addr(cmd_addr)
  );

  dbg_ack_gen #(.LOW_CYC(ACK_LOW)) u_ack (
    .clk(clk), .rst_n(rst_sn), .start(ack_start),
    .oe(line_oe), .lvl(line_out), .done(ack_done)
  );

  dbg_data_tx #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_sn), .en(st_q == SQ_DATA), .req(tx_req),
    .data(rd_q), .bit_o(tx_bit), .bit_vld(tx_bit_vld), .last(tx_last)
  );

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    rd_d      = rd_q;
    sts_d     = sts_q;
    ack_start = 1'b0;
    case (st_q)
      SQ_IDLE: if (cmd_vld) begin
        st_d   = SQ_PEND;
        addr_d = cmd_addr;
        sts_d  = STS_BUSY;
      end
      SQ_PEND: if (stop_mode) begin
        st_d  = SQ_IDLE;
        sts_d = STS_DROP;
      end else if (mem_done) begin
        st_d      = SQ_ACK;
        rd_d      = mem_rdata;
        sts_d     = STS_OK;
        ack_start = 1'b1;
      end
      SQ_ACK:  if (ack_done) st_d = SQ_DATA;
      SQ_DATA: if (tx_last)  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      rd_q   <= '0;
      sts_q  <= STS_OK;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      sts_q  <= sts_d;
    end
  end

  assign mem_req    = (st_q == SQ_PEND);
  assign mem_addr   = addr_q;
  assign cmd_status = sts_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_done && !stop_mode) |=> mem_req); // R3
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_done) |=> !mem_req); // R3
  AST_STOP_DISCARD: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && stop_mode) |=> (!mem_req && !line_oe && cmd_status == STS_DROP)); // R6
  AST_NO_DRIVE_PEND: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> !line_oe); // R4
  AST_BUSY_CODE: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> (cmd_status == STS_BUSY)); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_done && !stop_mode) |=> $stable(mem_addr)); // R8
  AST_OK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_done && !stop_mode) |=> (cmd_status == STS_OK)); // R7
  AST_TX_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_bit_vld |-> !line_oe); // R5
endmodule

// File: tb/tb_dbg_rd_seq.sv
`timescale 1ns/1ps
module tb_dbg_rd_seq;
  localparam logic [7:0] RDC = 8'hE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit_vld = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic        stop_mode = 1'b0, mem_done = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        tx_bit, tx_bit_vld, line_oe, line_out, mem_req;
  logic [23:0] mem_addr;
  logic [2:0]  cmd_status;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  dbg_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .tx_req(tx_req), .tx_bit(tx_bit), .tx_bit_vld(tx_bit_vld),
    .line_oe(line_oe), .line_out(line_out), .stop_mode(stop_mode),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .cmd_status(cmd_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_model(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      rx_bit_vld = 1'b1;
      rx_bit     = v[i];
    end
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic run_read(input logic [23:0] a, input int lat, input bit inject);
    logic [7:0] d;
    d = mem_model(a);
    send_bits({RDC, a}, 32);
    @(negedge clk);
    chk("R1 mem_req", mem_req, 1);
    chk("R1 mem_addr", mem_addr, a);
    chk("R8 busy status", cmd_status, 3'b100);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    @(negedge clk);
    chk("R5 early tx_req ignored", tx_bit_vld, 0);
    if (inject) begin
      send_bits({RDC, ~a}, 32);
      chk("R8 addr kept", mem_addr, a);
      chk("R8 still pending", mem_req, 1);
    end
    for (int k = 0; k < lat; k++) begin
      chk("R4 no drive while pending", line_oe, 0);
      @(negedge clk);
    end
    chk("R3 req held", mem_req, 1);
    mem_done  = 1'b1;
    mem_rdata = d;
    @(negedge clk);
    mem_done  = 1'b0;
    mem_rdata = 8'h00;
    chk("R3 req dropped", mem_req, 0);
    for (int j = 0; j < 16; j++) begin
      chk("R4 ack low", {line_oe, line_out}, 2'b10);
      @(negedge clk);
    end
    chk("R4 ack high", {line_oe, line_out}, 2'b11);
    @(negedge clk);
    chk("R4 released", line_oe, 0);
    chk("R7 status ok", cmd_status, 3'b000);
    for (int b = 7; b >= 0; b--) begin
      tx_req = 1'b1;
      @(negedge clk);
      chk("R5 data bit", {tx_bit_vld, tx_bit}, {1'b1, d[b]});
    end
    tx_req = 1'b0;
    @(negedge clk);
    chk("R5 shift done", tx_bit_vld, 0);
    repeat (3) @(negedge clk);
    chk("R8 no second request", mem_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 mem_req", mem_req, 0);
    chk("R9 line_oe", line_oe, 0);
    chk("R9 tx_bit_vld", tx_bit_vld, 0);
    chk("R9 status", cmd_status, 3'b000);

    // R2: every code other than the read-byte code is dropped
    for (int c = 0; c < 256; c++) begin
      if (c[7:0] != RDC) begin
        send_bits({24'h0, c[7:0]}, 8);
        @(negedge clk);
        @(negedge clk);
        chk("R2 rejected code", mem_req, 0);
      end
    end
    send_bits(32'h0000_0012, 8);
    run_read(24'h123456, 2, 1'b0);

    // R1 R3 R4 R5: walking-one addresses, varied latency
    for (int i = 0; i < 24; i++)
      run_read(24'h1 << i, 1 + (i % 5), (i % 4) == 0);
    run_read(24'h000000, 3, 1'b1);
    run_read(24'hFFFFFF, 5, 1'b0);

    // R6: stop while pending
    send_bits({RDC, 24'hABCDEF}, 32);
    @(negedge clk);
    chk("R6 pending", mem_req, 1);
    stop_mode = 1'b1;
    @(negedge clk);
    stop_mode = 1'b0;
    chk("R6 req dropped", mem_req, 0);
    chk("R6 status dropped", cmd_status, 3'b001);
    for (int k = 0; k < 30; k++) begin
      chk("R6 no ack", line_oe, 0);
      @(negedge clk);
    end
    stop_mode = 1'b1;
    @(negedge clk);
    stop_mode = 1'b0;
    @(negedge clk);
    chk("R6 status held", cmd_status, 3'b001);
    send_bits(32'h0000_0055, 8);
    @(negedge clk);
    chk("R6 status held after bad code", cmd_status, 3'b001);
    run_read(24'h0F0F0F, 4, 1'b0);
    chk("R7 status cleared", cmd_status, 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule